// File: doc/BRIEF.md
# Prioritized Interrupt Status and Mask Controller

This block gathers thirteen peripheral interrupt request lines into a 32-bit pending-status register and reduces them to a single 3-bit auto-vector priority level for a 68k-style processor. Each request line owns one fixed, irregularly placed bit of the status register. Each line also belongs to one of three processor priority groups: 3, 5 or 6. A 32-bit enable register decides which status bits may take part in the priority decision. The block drives the processor with the highest group that has at least one bit both pending and enabled.

Software reads and writes the status and enable registers through a simple 32-bit register port, so pending bits can be cleared or forced by the host as well as by the request lines. A separate byte-wide strobe from a storage-controller control register drives one status bit directly, as a processor-DMA indicator. Vector generation and the acknowledge cycle are handled elsewhere.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the status register, the enable register and `cpu_ipl` are all zero.
- R2: A rising edge on request line `src_req[i]` sets its status bit one clock later. The lines in index order 0..12 map to status bits 2, 3, 5, 7, 9, 10, 12, 17, 21, 23, 26, 27, 28.
- R3: A falling edge on a request line clears its status bit one clock later. A line held steady leaves its bit free for host writes.
- R4: With `reg_wr` high, a write to offset 0x7000 replaces the status register and a write to offset 0x7800 replaces the enable register, and each takes effect one clock later. `reg_rdata` shows the register at `reg_addr` combinationally. Other offsets read as zero and writes to them change nothing.
- R5: With `ctl_wr` high, bit 4 of `ctl_data` is copied into status bit 26 one clock later. The other bits of `ctl_data` have no effect.
- R6: When several updates hit the same status bit in one cycle, a request-line edge wins over a control-byte write, and a control-byte write wins over a host status write.
- R7: `cpu_ipl` is 6 if any of status bits 21, 23, 26, 27 or 28 is set with its enable bit set. Otherwise it is 5 if bit 17 is set and enabled. Otherwise it is 3 if any of bits 2, 3, 5, 7, 9, 10 or 12 is set and enabled. Otherwise it is 0. Status bits outside these groups never raise it. It changes in the same clock as the registers it depends on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 13 | Peripheral request lines, index order as in R2 |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 16 | Host register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` |
| ctl_wr | input | 1 | Storage-controller control byte write strobe |
| ctl_data | input | 8 | Control byte; bit 4 drives status bit 26 |
| cpu_ipl | output | 3 | Encoded processor priority level (0, 3, 5 or 6) |

## Verification
The bench builds the block with its default parameters: register offsets 0x7000 and 0x7800, control bit 4 steering status bit 26, and the thirteen-source map. With these defaults the control byte and the SCSI DMA request line land on the same status bit, which brings the three-way same-cycle precedence within reach. Host-written status bits outside every group are also exercised, to show they cannot raise the level. A behavioural model follows every cycle through single-source edges, random source and enable mixes, and deliberate collisions.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 13;
    localparam int BIT_W   = $clog2(DATA_W);

    // status bit owned by each request line, index order fixed by the port
    localparam logic [BIT_W-1:0] SRC_BIT [NUM_SRC] = '{
        5'd2, 5'd3, 5'd5, 5'd7, 5'd9, 5'd10, 5'd12,
        5'd17,
        5'd21, 5'd23, 5'd26, 5'd27, 5'd28
    };

    // processor priority group of each request line
    localparam logic [2:0] SRC_LVL [NUM_SRC] = '{
        3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3,
        3'd5,
        3'd6, 3'd6, 3'd6, 3'd6, 3'd6
    };

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] mask;
    } pirq_regs_t;

    function automatic logic [DATA_W-1:0] group_mask(input logic [2:0] lvl);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (SRC_LVL[i] == lvl) m[SRC_BIT[i]] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [NUM_SRC-1:0] src_on_bit(input int b);
        logic [NUM_SRC-1:0] s;
        s = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(SRC_BIT[i]) == b) s[i] = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/pirq_edge.sv
module pirq_edge #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise = line & ~prev_q;
    assign fall = ~line & prev_q;
endmodule

// File: rtl/pirq_prio_enc.sv
module pirq_prio_enc
    import pirq_pkg::*;
(
    input  logic [DATA_W-1:0] pend,
    output logic [2:0]        lvl
);
    localparam int NUM_GRP = 3;
    // index 0 is the strongest group
    localparam logic [2:0] GRP_LVL [NUM_GRP] = '{3'd6, 3'd5, 3'd3};

    logic [NUM_GRP-1:0] hit;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign hit[g] = |(pend & group_mask(GRP_LVL[g]));
    end

    always_comb begin
        lvl = 3'd0;
        for (int g = NUM_GRP - 1; g >= 0; g--) begin
            if (hit[g]) lvl = GRP_LVL[g];
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pirq_pkg::*;
#(
    parameter int                ADDR_W         = 16,
    parameter logic [ADDR_W-1:0] STATUS_OFF     = 16'h7000,
    parameter logic [ADDR_W-1:0] MASK_OFF       = 16'h7800,
    parameter int                CTL_W          = 8,
    parameter int                CTL_DMA_BIT    = 4,
    parameter int                CTL_STATUS_BIT = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               ctl_wr,
    input  logic [CTL_W-1:0]   ctl_data,
    output logic [2:0]         cpu_ipl
);
    localparam logic [NUM_SRC-1:0] CTL_SRC_SEL = src_on_bit(CTL_STATUS_BIT);
    localparam logic [DATA_W-1:0]  GRP6        = group_mask(3'd6);

    pirq_regs_t        regs_d, regs_q;
    logic [2:0]        ipl_d, ipl_q;
    logic [NUM_SRC-1:0] rise, fall;
    logic [DATA_W-1:0] pend_d;

    pirq_edge #(.N(NUM_SRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (src_req),
        .rise  (rise),
        .fall  (fall)
    );

    // precedence by order: host write, then control byte, then line edges
    always_comb begin
        regs_d = regs_q;
        if (reg_wr && reg_addr == STATUS_OFF) regs_d.status = reg_wdata;
        if (reg_wr && reg_addr == MASK_OFF)   regs_d.mask   = reg_wdata;
        if (ctl_wr) regs_d.status[CTL_STATUS_BIT] = ctl_data[CTL_DMA_BIT];
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rise[i])      regs_d.status[SRC_BIT[i]] = 1'b1;
            else if (fall[i]) regs_d.status[SRC_BIT[i]] = 1'b0;
        end
    end

    assign pend_d = regs_d.status & regs_d.mask;

    pirq_prio_enc u_enc (
        .pend (pend_d),
        .lvl  (ipl_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
            ipl_q  <= 3'd0;
        end else begin
            regs_q <= regs_d;
            ipl_q  <= ipl_d;
        end
    end

    always_comb begin
        if (reg_addr == STATUS_OFF)    reg_rdata = regs_q.status;
        else if (reg_addr == MASK_OFF) reg_rdata = regs_q.mask;
        else                           reg_rdata = '0;
    end

    assign cpu_ipl = ipl_q;

    // ---------------- assertions ----------------
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> regs_q.status[SRC_BIT[i]]);
        a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> !regs_q.status[SRC_BIT[i]]);
    end

    a_r4_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == MASK_OFF) |=> regs_q.mask == $past(reg_wdata));

    a_r5_ctl_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !(|((rise | fall) & CTL_SRC_SEL)))
        |=> regs_q.status[CTL_STATUS_BIT] == $past(ctl_data[CTL_DMA_BIT]));

    a_r7_ipl_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ipl inside {3'd0, 3'd3, 3'd5, 3'd6});

    a_r7_top_group: assert property (@(posedge clk) disable iff (!rst_n)
        (|(regs_q.status & regs_q.mask & GRP6)) |-> cpu_ipl == 3'd6);

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q.status & regs_q.mask) == '0) |-> cpu_ipl == 3'd0);
endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] src_req = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = 16'h7000;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_data = '0;
    logic [2:0]  cpu_ipl;

    always #2 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .cpu_ipl(cpu_ipl)
    );

    // bit positions and groups as stated in R2 and R7
    logic [4:0] pos [13] = '{5'd2, 5'd3, 5'd5, 5'd7, 5'd9, 5'd10, 5'd12,
                             5'd17, 5'd21, 5'd23, 5'd26, 5'd27, 5'd28};
    logic [31:0] grp3 = 32'h0000_16AC;  // bits 2,3,5,7,9,10,12
    logic [31:0] grp5 = 32'h0002_0000;  // bit 17
    logic [31:0] grp6 = 32'h1CA0_0000;  // bits 21,23,26,27,28

    int checks = 0;
    int fails  = 0;
    string cur = "R1";

    // behavioural reference model
    logic [31:0] m_status = '0, m_mask = '0;
    logic [12:0] m_prev = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = '0; m_mask = '0; m_prev = '0;
        end else begin
            if (reg_wr && reg_addr == 16'h7000) m_status = reg_wdata;
            if (reg_wr && reg_addr == 16'h7800) m_mask = reg_wdata;
            if (ctl_wr) m_status[26] = ctl_data[4];
            for (int i = 0; i < 13; i++) begin
                if (src_req[i] && !m_prev[i]) m_status[pos[i]] = 1'b1;
                if (!src_req[i] && m_prev[i]) m_status[pos[i]] = 1'b0;
            end
            m_prev = src_req;
        end
    end

    function automatic logic [2:0] exp_ipl(input logic [31:0] p);
        if ((p & grp6) != 0) return 3'd6;
        if ((p & grp5) != 0) return 3'd5;
        if ((p & grp3) != 0) return 3'd3;
        return 3'd0;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", cur, what, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            logic [31:0] er;
            @(negedge clk);
            if (reg_addr == 16'h7000)      er = m_status;
            else if (reg_addr == 16'h7800) er = m_mask;
            else                           er = '0;
            chk("rdata", reg_rdata, er);
            chk("ipl", {29'd0, cpu_ipl}, {29'd0, exp_ipl(m_status & m_mask)});
        end
    endtask

    task automatic hwrite(input logic [15:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_addr = 16'h7000;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired in %s", cur);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur = "R1";
        chk("ipl at reset", {29'd0, cpu_ipl}, 32'd0);
        chk("status at reset", reg_rdata, 32'd0);
        rst_n = 1'b1;
        step(2);
        reg_addr = 16'h7800; step();
        chk("mask after reset", reg_rdata, 32'd0);
        reg_addr = 16'h7000;

        cur = "R4";
        hwrite(16'h7800, 32'hFFFF_FFFF);
        reg_addr = 16'h7800; step();
        hwrite(16'h7004, 32'hDEAD_BEEF);
        reg_addr = 16'h7004; step();
        reg_addr = 16'h7800; step();
        hwrite(16'h7000, 32'h0000_0000);

        for (int i = 0; i < 13; i++) begin
            cur = "R2";
            src_req[i] = 1'b1; step(2);
            cur = "R3";
            src_req[i] = 1'b0; step(2);
        end

        cur = "R7";
        hwrite(16'h7800, 32'h0);
        src_req = 13'h1FFF; step(2);
        hwrite(16'h7800, grp3); step();
        hwrite(16'h7800, grp3 | grp5); step();
        hwrite(16'h7800, 32'hFFFF_FFFF); step();
        src_req = '0; step(2);
        hwrite(16'h7000, ~(grp3 | grp5 | grp6));
        hwrite(16'h7000, 32'h0002_0004);
        hwrite(16'h7000, 32'h0);
        for (int k = 0; k < 400; k++) begin
            src_req = 13'($urandom);
            if (($urandom % 8) == 0) begin
                reg_wr = 1'b1;
                reg_addr = (($urandom % 2) == 0) ? 16'h7000 : 16'h7800;
                reg_wdata = $urandom;
            end
            step();
            reg_wr = 1'b0;
            reg_addr = (($urandom % 3) == 0) ? 16'h7800 : 16'h7000;
        end
        src_req = '0; reg_addr = 16'h7000; step(2);

        cur = "R5";
        ctl_wr = 1'b1; ctl_data = 8'h10; step();
        ctl_data = 8'hEF; step();
        ctl_data = 8'h10; step();
        ctl_wr = 1'b0; ctl_data = 8'hFF; step(2);
        ctl_wr = 1'b1; ctl_data = 8'h00; step();
        ctl_wr = 1'b0; step();

        cur = "R6";
        src_req[10] = 1'b1; ctl_wr = 1'b1; ctl_data = 8'h00;
        reg_wr = 1'b1; reg_wdata = 32'h0; step();
        ctl_wr = 1'b0; reg_wr = 1'b0; step();
        src_req[10] = 1'b0; ctl_wr = 1'b1; ctl_data = 8'h10;
        reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; step();
        ctl_wr = 1'b0; reg_wr = 1'b0; step();
        ctl_wr = 1'b1; ctl_data = 8'h00; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; step();
        ctl_wr = 1'b0; reg_wr = 1'b0; step();
        src_req = 13'h1FFF; step();
        src_req = 13'h0000; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; step();
        reg_wr = 1'b0; step(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule